// File: doc/BRIEF.md
# Robbed-Bit Frame Classifier and Receive Expander

This block sits on the receive side of one PCM voice channel. It watches the frame sync line against the PCM bit clock and measures how long each sync pulse is. A frame whose pulse is exactly two bit clocks long, following a pulse that was not, is a signaling frame. All other frames are ordinary. The classification is taken when the pulse ends and held for the rest of that frame.

Each received companded byte arrives as one beat on a valid/ready stream. The block expands it to a signed linear sample with G.711 µ-law or A-law rules. In a signaling frame under µ-law, the block discards the received lowest mantissa bit and puts a value of half that bit's weight in its place. This caps the error from the stolen bit at half a step. The linear samples leave on a second valid/ready stream.

Back-pressure rules: a byte is accepted on a falling clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high when the output register is empty or is being emptied in that cycle. While `out_valid_o` is high and `out_ready_i` is low, the output sample does not change. Neither side may withdraw a beat that it has offered.

Top module: `rbx_rx_expander`

## Requirements
- R1: All state is updated on the falling edge of `pclk_i`. Frame sync is seen only as its value at those edges. A pulse's length is the number of consecutive edges that see it high, and the pulse ends at the first edge that sees it low. A level that rises and falls between two falling edges has no effect.
- R2: When a pulse ends, the frame is classified as signaling only if all of these hold: `rb_en_i`=1, `mulaw_i`=1 (1 selects µ-law, 0 selects A-law), the pulse length is exactly 2, and the previous pulse length was not 2.
- R3: In a µ-law signaling frame, mantissa bit 0 of the byte is ignored. The magnitude in output units is ((4·{m3,m2,m1,0}+2+66)<<seg)−66. For example, bytes 0xFF and 0xFE both give 2, 0x80 gives 15806 and 0x00 gives −15806.
- R4: In a normal frame, a µ-law byte is bit-inverted. Bit 7 set then means negative, bits 6:4 are the segment and bits 3:0 the mantissa m. The magnitude is ((4m+66)<<seg)−66. The output is signed 16-bit, and one count is half a unit of the 14-bit µ-law scale.
- R5: An A-law byte is XORed with 0x55. Bit 7 set then means positive. The magnitude is 4·(2m+1) for segment 0 and 4·((2m+33)<<(seg−1)) otherwise. No substitution is ever made in A-law, even with `rb_en_i`=1 and a two-cycle pulse.
- R6: A pulse of 1 cycle, or of 3 or more cycles, counts as "not 2". Two consecutive two-cycle pulses give a signaling frame followed by a normal frame.
- R7: The classification is held from one pulse end to the next. Changing `rb_en_i` within a frame does not alter it.
- R8: A byte accepted at one falling edge is presented as `out_valid_o`=1 with its sample right after that edge. `in_ready_o` is low only while the output is full and stalled, and a stalled output holds its sample.
- R9: Asynchronous reset (`rst_n_i` low) empties the output, sets the frame class to normal and clears the previous-pulse record. The first two-cycle pulse after reset therefore yields a signaling frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | PCM bit clock; falling edge is active |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame sync level |
| rb_en_i | input | 1 | Robbed-bit substitution enable |
| mulaw_i | input | 1 | 1 = µ-law, 0 = A-law |
| in_valid_i | input | 1 | Received byte offered (valid time slot) |
| in_ready_o | output | 1 | Byte can be taken this edge |
| in_byte_i | input | 8 | Received companded byte |
| out_valid_o | output | 1 | Linear sample available |
| out_ready_i | input | 1 | Consumer takes the sample |
| out_sample_o | output | SAMPLE_W | Signed linear sample, half-unit resolution |

## Verification
The frame class is not visible at the ports. It depends on two pulses in a row, so it can only be seen through the sample values of bytes sent after each pulse. The bench therefore runs a chain of frames whose pulse lengths are chosen so that the previous-pulse record takes both values before each two-cycle pulse. It reads the class back from the low-weight bits of the expanded samples. A sub-edge sync glitch, placed between two two-cycle pulses, shows up as a wrong class on the second pulse if the glitch were counted.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  typedef enum logic {
    FRAME_NORMAL = 1'b0,
    FRAME_ROBBED = 1'b1
  } frame_class_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LIN_W    = 16;
  localparam logic [7:0]  ALAW_XOR = 8'h55;
  localparam logic [15:0] MU_BIAS  = 16'd66;
endpackage

// File: rtl/rbx_sync_classifier.sv
module rbx_sync_classifier
  import rbx_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 2
) (
  input  logic         pclk_i,
  input  logic         rst_n_i,
  input  logic         fs_i,
  input  logic         rb_en_i,
  input  logic         mulaw_i,
  output frame_class_e class_o,
  output logic         pulse_end_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 2);
  localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TARGET = CNT_W'(PULSE_CYCLES);

  logic             fs_q;
  logic [CNT_W-1:0] run_cnt;
  logic             last_was_target;
  frame_class_e     class_q;
  logic             hit_target;

  assign pulse_end_o = fs_q && !fs_i;
  assign hit_target  = (run_cnt == CNT_TARGET);
  assign class_o     = class_q;

  always_ff @(negedge pclk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fs_q            <= 1'b0;
      run_cnt         <= '0;
      last_was_target <= 1'b0;
      class_q         <= FRAME_NORMAL;
    end else begin
      fs_q <= fs_i;
      if (fs_i) begin
        if (!fs_q)                run_cnt <= CNT_W'(1);
        else if (run_cnt != CNT_SAT) run_cnt <= run_cnt + CNT_W'(1);
      end
      if (pulse_end_o) begin
        last_was_target <= hit_target;
        class_q <= (rb_en_i && mulaw_i && hit_target && !last_was_target)
                   ? FRAME_ROBBED : FRAME_NORMAL;
      end
    end
  end
endmodule

// File: rtl/rbx_law_expander.sv
module rbx_law_expander
  import rbx_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = 16,
  parameter bit          SUPPORT_ALAW = 1'b1
) (
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                mulaw_i,
  input  logic                robbed_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  logic [7:0]       code;
  logic [2:0]       seg;
  logic [3:0]       man;
  logic [5:0]       mu_step;
  logic [LIN_W-1:0] mu_mag;
  logic [LIN_W-1:0] a_mag;
  logic [LIN_W-1:0] mag;
  logic [LIN_W-1:0] signed_lin;
  logic             negative;

  assign code = mulaw_i ? ~byte_i : (byte_i ^ ALAW_XOR);
  assign seg  = code[6:4];
  assign man  = code[3:0];

  // robbed: bit 0 of the mantissa replaced by half its weight
  assign mu_step = (mulaw_i && robbed_i) ? {man[3:1], 1'b0, 2'b10}
                                         : {man, 2'b00};
  assign mu_mag  = ((LIN_W'(mu_step) + MU_BIAS) << seg) - MU_BIAS;

  generate
    if (SUPPORT_ALAW) begin : g_alaw
      logic [LIN_W-1:0] a_lin;
      always_comb begin
        if (seg == 3'd0) a_lin = LIN_W'({man, 1'b1});
        else             a_lin = LIN_W'({1'b1, man, 1'b1}) << (seg - 3'd1);
      end
      assign a_mag = a_lin << 2;
    end else begin : g_no_alaw
      assign a_mag = '0;
    end
  endgenerate

  assign negative   = mulaw_i ? code[7] : !code[7];
  assign mag        = mulaw_i ? mu_mag : a_mag;
  assign signed_lin = negative ? (~mag + LIN_W'(1)) : mag;
  assign sample_o   = SAMPLE_W'($signed(signed_lin));
endmodule

// File: rtl/rbx_out_stage.sv
module rbx_out_stage #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                pclk_i,
  input  logic                rst_n_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_data_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [SAMPLE_W-1:0] out_data_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(negedge pclk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= in_data_i;
    end
  end
endmodule

// File: rtl/rbx_rx_expander.sv
module rbx_rx_expander
  import rbx_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 2,
  parameter int unsigned SAMPLE_W     = 16,
  parameter bit          SUPPORT_ALAW = 1'b1
) (
  input  logic                pclk_i,
  input  logic                rst_n_i,
  input  logic                fs_i,
  input  logic                rb_en_i,
  input  logic                mulaw_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [7:0]          in_byte_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [SAMPLE_W-1:0] out_sample_o
);
  frame_class_e        frame_class;
  logic                pulse_end;
  logic                robbed;
  logic [SAMPLE_W-1:0] lin_sample;

  rbx_sync_classifier #(.PULSE_CYCLES(PULSE_CYCLES)) u_cls (
    .pclk_i      (pclk_i),
    .rst_n_i     (rst_n_i),
    .fs_i        (fs_i),
    .rb_en_i     (rb_en_i),
    .mulaw_i     (mulaw_i),
    .class_o     (frame_class),
    .pulse_end_o (pulse_end)
  );

  assign robbed = (frame_class == FRAME_ROBBED);

  rbx_law_expander #(.SAMPLE_W(SAMPLE_W), .SUPPORT_ALAW(SUPPORT_ALAW)) u_exp (
    .byte_i   (in_byte_i),
    .mulaw_i  (mulaw_i),
    .robbed_i (robbed),
    .sample_o (lin_sample)
  );

  rbx_out_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
    .pclk_i      (pclk_i),
    .rst_n_i     (rst_n_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (lin_sample),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_sample_o)
  );
endmodule

// File: rtl/rbx_rx_expander_chk.sv
module rbx_rx_expander_chk #(
  parameter int unsigned SAMPLE_W = 16
) (
  input logic                pclk_i,
  input logic                rst_n_i,
  input logic                rb_en_i,
  input logic                mulaw_i,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic [SAMPLE_W-1:0] out_sample_o,
  input logic                robbed,
  input logic                pulse_end
);
  a_r8_stall_holds: assert property (@(negedge pclk_i) disable iff (!rst_n_i)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_sample_o)));

  a_r8_accept_shows: assert property (@(negedge pclk_i) disable iff (!rst_n_i)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  a_r2_needs_mode: assert property (@(negedge pclk_i) disable iff (!rst_n_i)
    $rose(robbed) |-> $past(rb_en_i && mulaw_i && pulse_end));

  a_r6_no_two_in_row: assert property (@(negedge pclk_i) disable iff (!rst_n_i)
    (robbed && pulse_end) |=> !robbed);

  a_r7_class_held: assert property (@(negedge pclk_i) disable iff (!rst_n_i)
    !pulse_end |=> $stable(robbed));

  a_r5_alaw_grid: assert property (@(negedge pclk_i) disable iff (!rst_n_i)
    (in_valid_i && in_ready_o && !mulaw_i) |=> (out_sample_o[1:0] == 2'b00));
endmodule

bind rbx_rx_expander rbx_rx_expander_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .pclk_i       (pclk_i),
  .rst_n_i      (rst_n_i),
  .rb_en_i      (rb_en_i),
  .mulaw_i      (mulaw_i),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_sample_o (out_sample_o),
  .robbed       (robbed),
  .pulse_end    (pulse_end)
);

// File: tb/rbx_rx_expander_tb.sv
module rbx_rx_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic        rb_en = 1'b1;
  logic        mulaw = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_sample;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rbx_rx_expander dut_i (
    .pclk_i(clk), .rst_n_i(rst_n), .fs_i(fs), .rb_en_i(rb_en), .mulaw_i(mulaw),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_byte_i(in_byte),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_sample_o(out_sample)
  );

  // {mulaw, rb_en, pulse length, byte, expected sample}; run in order
  localparam int NV = 17;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd2, 8'hFF, 16'h0002},  // R9 first 2-pulse after reset, R3
    {1'b1, 1'b1, 3'd2, 8'hFF, 16'h0000},  // R6 second 2-pulse in a row
    {1'b1, 1'b1, 3'd1, 8'hFE, 16'h0004},  // R4
    {1'b1, 1'b1, 3'd2, 8'hFE, 16'h0002},  // R3 LSB ignored
    {1'b1, 1'b1, 3'd3, 8'h80, 16'h3EBE},  // R4 3-pulse normal
    {1'b1, 1'b1, 3'd2, 8'h80, 16'h3DBE},  // R3
    {1'b1, 1'b0, 3'd1, 8'h00, 16'hC142},  // R4
    {1'b1, 1'b0, 3'd2, 8'h00, 16'hC142},  // R2 enable clear
    {1'b1, 1'b1, 3'd4, 8'h00, 16'hC142},  // R6 long pulse
    {1'b1, 1'b1, 3'd2, 8'h00, 16'hC242},  // R3 negative
    {1'b0, 1'b1, 3'd1, 8'hD5, 16'h0004},  // R5
    {1'b0, 1'b1, 3'd2, 8'hD4, 16'h000C},  // R5
    {1'b0, 1'b1, 3'd3, 8'h2A, 16'hC100},  // R5
    {1'b0, 1'b1, 3'd2, 8'hAA, 16'h3F00},  // R5 no substitution in A-law
    {1'b1, 1'b1, 3'd1, 8'hEF, 16'h0042},  // R4
    {1'b1, 1'b1, 3'd2, 8'hEF, 16'h0046},  // R3
    {1'b1, 1'b1, 3'd2, 8'h7F, 16'h0000}   // R6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); fs = 1'b1;
    end
    @(posedge clk); fs = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic send(input string req, input logic [7:0] b, input logic [15:0] exp);
    @(posedge clk); in_valid = 1'b1; in_byte = b;
    @(posedge clk);
    check({req, " valid"}, {15'd0, out_valid}, 16'd1);
    check(req, out_sample, exp);
    in_valid = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    check("R9 reset out_valid", {15'd0, out_valid}, 16'd0);
    check("R9 reset in_ready", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      mulaw = VEC[v][28];
      rb_en = VEC[v][27];
      pulse(int'(VEC[v][26:24]));
      send($sformatf("R2 vector %0d", v), VEC[v][23:16], VEC[v][15:0]);
    end

    // R7: class kept through the frame after enable drops
    mulaw = 1'b1; rb_en = 1'b1;
    pulse(1); pulse(2);
    rb_en = 1'b0;
    send("R7 first byte", 8'hFF, 16'h0002);
    send("R7 second byte", 8'hFE, 16'h0002);
    pulse(1);
    send("R7 next frame normal", 8'hFF, 16'h0000);
    rb_en = 1'b1;

    // R1: glitch between falling edges is not a pulse
    pulse(2);
    @(posedge clk); #1 fs = 1'b1; #2 fs = 1'b0;
    repeat (2) @(posedge clk);
    pulse(2);
    send("R1 glitch ignored", 8'hFF, 16'h0000);

    // R8: back-pressure
    pulse(1);
    out_ready = 1'b0;
    @(posedge clk); in_valid = 1'b1; in_byte = 8'hFE;
    @(posedge clk);
    check("R8 first held", out_sample, 16'h0004);
    check("R8 ready low", {15'd0, in_ready}, 16'd0);
    in_byte = 8'hEF;
    @(posedge clk);
    check("R8 stalled stable", out_sample, 16'h0004);
    check("R8 stalled valid", {15'd0, out_valid}, 16'd1);
    out_ready = 1'b1;
    @(posedge clk);
    check("R8 second after release", out_sample, 16'h0042);
    in_valid = 1'b0;
    @(posedge clk);
    check("R8 drained", {15'd0, out_valid}, 16'd0);

    // R9: reset clears previous-pulse record (it is set here)
    pulse(2);
    @(posedge clk); rst_n = 1'b0;
    @(posedge clk);
    check("R9 reset mid-run", {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;
    pulse(2);
    send("R9 robbed after reset", 8'hFF, 16'h0002);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule